// File: doc/BRIEF.md
# Software-Managed Translation Lookaside Buffer

This block is the translation array of an embedded processor whose page tables are walked by software. Software fills entries through two write ports: a tag port that loads an entry's page base, size code, valid flag and attribute byte from one word, and a data port that loads the real page number and permission bits. The process ID in force is captured into the entry when its tag is written.

A search port takes an effective address and, in the same cycle, returns the lowest index whose entry matches, or all ones when none does. It also returns the translated real address and the permission and attribute fields of that entry. Each entry carries its own page size, from 1 KiB to 16 MiB in steps of four, and an entry written under process ID zero matches every process. A four-bit condition field for the recording form of the search instruction is produced alongside the result.

Top module: `soft_tlb`

## Requirements
- R1: The search result is the lowest index among the matching entries, zero-extended to the result width, and `srch_hit` is 1; when no entry matches, the result is all ones, `srch_hit` is 0 and `srch_ra`, `srch_perm` and `srch_attr` are 0.
- R2: An entry takes part in matching only while its valid flag is set; the flag is loaded from bit 6 of the tag word, so a tag write with bit 6 clear removes the entry. Reset clears every valid flag.
- R3: An entry whose stored process ID is zero matches under any value of `pid_cur`; any other stored process ID matches only when equal to `pid_cur`.
- R4: The stored process ID is the value of `pid_cur` in the cycle of the tag write; later changes of `pid_cur` do not alter it.
- R5: Bits 9:7 of the tag word give a size code c; the page size is 1 KiB × 4^c and the page mask is the inverse of (size − 1). An entry matches when the search address ANDed with its mask equals its stored page base.
- R6: The stored page base is the tag word with bits 9:0 cleared and every bit below the page size cleared, so an unaligned base written into a large page still matches the whole aligned page.
- R7: The real address is the stored real page number under the page mask ORed with the search address outside the mask; the real page number is the data word with bits 9:0 cleared.
- R8: On a hit, `srch_attr` is bits 7:0 of the tag word last written to that entry and `srch_perm` is the permission value last written to it through the data port.
- R9: `cr0` is {0, 0, hit, `xer_so`}: bit 0 copies the summary-overflow input and bit 1 is set when the search hits.
- R10: The search is combinational; a write becomes visible to searches from the cycle after its clock edge, and a search in the same cycle as the write sees the old contents.
- R11: A data-port write changes neither the valid flag, the page base, the size nor the process ID of the entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pid_cur | input | PIDW | Current process ID register value |
| tag_we | input | 1 | Tag-port write strobe |
| data_we | input | 1 | Data-port write strobe |
| wr_idx | input | IDXW | Entry index for either write |
| wr_tag | input | AW | Tag word: page base 31:10, size code 9:7, valid 6, attribute byte 7:0 |
| wr_data | input | AW | Data word: real page number in bits 31:10 |
| wr_perm | input | PERMW | Permission bits stored by the data port |
| srch_ea | input | AW | Effective address to search |
| xer_so | input | 1 | Summary-overflow bit for the condition field |
| srch_hit | output | 1 | Some entry matches |
| srch_result | output | RESW | Lowest matching index or all ones |
| srch_ra | output | AW | Translated real address |
| srch_perm | output | PERMW | Permission bits of the matching entry |
| srch_attr | output | 8 | Attribute byte of the matching entry |
| cr0 | output | 4 | Condition field for the recording search form |

## Verification
The assertions assume that reset is held for at least one clock edge before any write and that `wr_idx`, `wr_tag`, `wr_data` and `pid_cur` are stable and free of unknowns at each rising edge where a write strobe is high. The bench drives every input on the falling edge, pulses each strobe for exactly one cycle, and leaves reset low across two rising edges before the first write. The search checks are taken one time unit after the falling edge on which the address was applied, so the combinational result has settled and no clock edge lies between stimulus and sample.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
   // Field positions inside the tag word (decoded by every slot)
   localparam int MIN_PG_BITS = 10;   // smallest page: 1 KiB
   localparam int SZ_W        = 3;    // size code width
   localparam int SZ_LSB      = 7;    // size code at [9:7]
   localparam int VALID_POS   = 6;    // valid flag
   localparam int ATTR_W      = 8;    // attribute byte [7:0]
   localparam int SZ_STEP     = 2;    // each code step multiplies size by 4
   localparam int MAX_PG_BITS = MIN_PG_BITS + SZ_STEP * ((1 << SZ_W) - 1);
endpackage

// File: rtl/tlb_first_match.sv
module tlb_first_match #(
   parameter int N    = 64,
   parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]    req,
   output logic [N-1:0]    sel,
   output logic [IDXW-1:0] idx,
   output logic            any
);
   // isolate the lowest set bit
   assign sel = req & (~req + N'(1));
   assign any = |req;

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDXW'(i);
      end
   end
endmodule

// File: rtl/tlb_slot.sv
module tlb_slot
   import soft_tlb_pkg::*;
#(
   parameter int AW    = 32,
   parameter int PIDW  = 8,
   parameter int PERMW = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tag_we,
   input  logic              data_we,
   input  logic [AW-1:0]     tag_word,
   input  logic [AW-1:0]     data_word,
   input  logic [PERMW-1:0]  perm_in,
   input  logic [PIDW-1:0]   pid_cur,
   input  logic [AW-1:0]     ea,
   output logic              match,
   output logic [AW-1:0]     ra,
   output logic [PERMW-1:0]  perm,
   output logic [ATTR_W-1:0] attr
);
   localparam logic [AW-1:0] PG_FLOOR = ~((AW'(1) << MIN_PG_BITS) - AW'(1));

   function automatic logic [AW-1:0] page_mask(input logic [SZ_W-1:0] code);
      return ~((AW'(1) << (MIN_PG_BITS + SZ_STEP * int'(code))) - AW'(1));
   endfunction

   logic              valid_q;
   logic [SZ_W-1:0]   code_q;
   logic [AW-1:0]     epn_q;
   logic [AW-1:0]     rpn_q;
   logic [PIDW-1:0]   pid_q;
   logic [ATTR_W-1:0] attr_q;
   logic [PERMW-1:0]  perm_q;
   logic [AW-1:0]     mask_q;
   logic [SZ_W-1:0]   code_in;

   assign code_in = tag_word[SZ_LSB +: SZ_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         code_q  <= '0;
         epn_q   <= '0;
         pid_q   <= '0;
         attr_q  <= '0;
      end else if (tag_we) begin
         valid_q <= tag_word[VALID_POS];
         code_q  <= code_in;
         epn_q   <= tag_word & PG_FLOOR & page_mask(code_in);
         pid_q   <= pid_cur;
         attr_q  <= tag_word[ATTR_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rpn_q  <= '0;
         perm_q <= '0;
      end else if (data_we) begin
         rpn_q  <= data_word & PG_FLOOR;
         perm_q <= perm_in;
      end
   end

   assign mask_q = page_mask(code_q);
   assign match  = valid_q && ((pid_q == '0) || (pid_q == pid_cur))
                   && ((ea & mask_q) == epn_q);
   assign ra     = (rpn_q & mask_q) | (ea & ~mask_q);
   assign perm   = perm_q;
   assign attr   = attr_q;

   // R6: stored base never carries bits below its page size
   assert_epn_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> ((epn_q & ~mask_q) == '0));

   // R2: valid flag follows bit 6 of the written tag word
   assert_valid_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tag_we |=> (valid_q == $past(tag_word[VALID_POS])));

   // R4: process ID captured at write time
   assert_pid_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tag_we |=> (pid_q == $past(pid_cur)));

   // R11: a data write alone leaves the tag half untouched
   assert_data_keeps_tag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !tag_we) |=> ($stable(valid_q) && $stable(epn_q) && $stable(pid_q)));
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
   import soft_tlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int AW      = 32,
   parameter int PIDW    = 8,
   parameter int PERMW   = 6,
   parameter int RESW    = 32,
   localparam int IDXW   = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIDW-1:0]   pid_cur,
   input  logic              tag_we,
   input  logic              data_we,
   input  logic [IDXW-1:0]   wr_idx,
   input  logic [AW-1:0]     wr_tag,
   input  logic [AW-1:0]     wr_data,
   input  logic [PERMW-1:0]  wr_perm,
   input  logic [AW-1:0]     srch_ea,
   input  logic              xer_so,
   output logic              srch_hit,
   output logic [RESW-1:0]   srch_result,
   output logic [AW-1:0]     srch_ra,
   output logic [PERMW-1:0]  srch_perm,
   output logic [ATTR_W-1:0] srch_attr,
   output logic [3:0]        cr0
);
   // elaboration-time parameter checks
   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("soft_tlb: ENTRIES must be at least 2");
      end
      if (AW < MAX_PG_BITS + 1) begin : g_bad_aw
         $error("soft_tlb: AW too narrow for the largest page");
      end
      if (RESW < IDXW + 1) begin : g_bad_resw
         $error("soft_tlb: RESW must exceed the index width");
      end
   endgenerate

   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] sel_vec;
   logic [IDXW-1:0]    first_idx;
   logic               any_hit;
   logic [AW-1:0]      slot_ra   [ENTRIES];
   logic [PERMW-1:0]   slot_perm [ENTRIES];
   logic [ATTR_W-1:0]  slot_attr [ENTRIES];

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
         logic sel_wr;
         assign sel_wr = (wr_idx == IDXW'(g));
         tlb_slot #(.AW(AW), .PIDW(PIDW), .PERMW(PERMW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .tag_we   (tag_we && sel_wr),
            .data_we  (data_we && sel_wr),
            .tag_word (wr_tag),
            .data_word(wr_data),
            .perm_in  (wr_perm),
            .pid_cur  (pid_cur),
            .ea       (srch_ea),
            .match    (hit_vec[g]),
            .ra       (slot_ra[g]),
            .perm     (slot_perm[g]),
            .attr     (slot_attr[g])
         );
      end
   endgenerate

   tlb_first_match #(.N(ENTRIES), .IDXW(IDXW)) u_first (
      .req(hit_vec),
      .sel(sel_vec),
      .idx(first_idx),
      .any(any_hit)
   );

   // AND-OR read mux driven by the one-hot select
   always_comb begin
      srch_ra   = '0;
      srch_perm = '0;
      srch_attr = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (sel_vec[i]) begin
            srch_ra   = srch_ra   | slot_ra[i];
            srch_perm = srch_perm | slot_perm[i];
            srch_attr = srch_attr | slot_attr[i];
         end
      end
   end

   assign srch_hit    = any_hit;
   assign srch_result = any_hit ? RESW'(first_idx) : '1;
   assign cr0         = {2'b00, any_hit, xer_so};

   // checks on the assembled search path
   logic [ENTRIES-1:0] below_first;
   assign below_first = (ENTRIES'(1) << first_idx) - ENTRIES'(1);

   assert_first_lowest_R1: assert property (@(posedge clk) disable iff (!rst_n)
      srch_hit |-> ((hit_vec & below_first) == '0) && hit_vec[first_idx]);

   assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_vec) && ($countones(sel_vec) == 32'(srch_hit)));

   assert_miss_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_hit |-> ((srch_result == '1) && (srch_ra == '0)));

   assert_cr0_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cr0[1] == (srch_result != '1));
endmodule

// File: tb/soft_tlb_test.sv
module soft_tlb_test;
   localparam int CLK_PERIOD = 10;
   localparam int ENTRIES = 64;
   localparam int AW = 32;
   localparam int PIDW = 8;
   localparam int PERMW = 6;
   localparam int RESW = 32;
   localparam int IDXW = $clog2(ENTRIES);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [PIDW-1:0]   pid_cur = '0;
   logic              tag_we = 1'b0;
   logic              data_we = 1'b0;
   logic [IDXW-1:0]   wr_idx = '0;
   logic [AW-1:0]     wr_tag = '0;
   logic [AW-1:0]     wr_data = '0;
   logic [PERMW-1:0]  wr_perm = '0;
   logic [AW-1:0]     srch_ea = '0;
   logic              xer_so = 1'b0;
   logic              srch_hit;
   logic [RESW-1:0]   srch_result;
   logic [AW-1:0]     srch_ra;
   logic [PERMW-1:0]  srch_perm;
   logic [7:0]        srch_attr;
   logic [3:0]        cr0;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   soft_tlb #(.ENTRIES(ENTRIES), .AW(AW), .PIDW(PIDW), .PERMW(PERMW), .RESW(RESW)) uut (
      .clk(clk), .rst_n(rst_n), .pid_cur(pid_cur), .tag_we(tag_we), .data_we(data_we),
      .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data), .wr_perm(wr_perm),
      .srch_ea(srch_ea), .xer_so(xer_so), .srch_hit(srch_hit), .srch_result(srch_result),
      .srch_ra(srch_ra), .srch_perm(srch_perm), .srch_attr(srch_attr), .cr0(cr0)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic write_tag(input int idx, input logic [AW-1:0] word);
      @(negedge clk);
      tag_we = 1'b1; wr_idx = IDXW'(idx); wr_tag = word;
      @(negedge clk);
      tag_we = 1'b0;
   endtask

   task automatic write_data(input int idx, input logic [AW-1:0] word, input logic [PERMW-1:0] p);
      @(negedge clk);
      data_we = 1'b1; wr_idx = IDXW'(idx); wr_data = word; wr_perm = p;
      @(negedge clk);
      data_we = 1'b0;
   endtask

   // applies an address on a falling edge and samples 1 time unit later
   task automatic search(input string req, input logic [AW-1:0] ea, input bit exp_hit,
                         input int exp_idx, input logic [AW-1:0] exp_ra);
      @(negedge clk);
      srch_ea = ea;
      #1;
      check(req, "hit", 64'(srch_hit), 64'(exp_hit));
      check(req, "result", 64'(srch_result), exp_hit ? 64'(exp_idx) : 64'(32'hFFFF_FFFF));
      if (exp_hit) check(req, "real address", 64'(srch_ra), 64'(exp_ra));
   endtask

   task automatic t_reset();
      xer_so = 1'b1;
      search("R1", 32'h0000_0000, 1'b0, 0, '0);
      check("R2", "ra after reset", 64'(srch_ra), 64'h0);
      check("R9", "cr0 on miss", 64'(cr0), 64'h1);
      xer_so = 1'b0;
   endtask

   task automatic t_basic();
      pid_cur = 8'd5;
      write_tag(3, 32'h0001_00C5);            // 4 KiB, valid, attr C5
      write_data(3, 32'h00AB_C000, 6'h2A);
      search("R5", 32'h0001_0123, 1'b1, 3, 32'h00AB_C123);
      check("R8", "perm", 64'(srch_perm), 64'h2A);
      check("R8", "attr", 64'(srch_attr), 64'hC5);
      check("R9", "cr0 on hit", 64'(cr0), 64'h2);
      search("R5", 32'h0001_1000, 1'b0, 0, '0);
   endtask

   task automatic t_priority();
      pid_cur = 8'd5;
      write_tag(10, 32'h0020_0040);
      write_data(10, 32'h2220_0000, 6'h01);
      write_tag(7, 32'h0020_0040);
      write_data(7, 32'h1110_0000, 6'h02);
      search("R1", 32'h0020_03FF, 1'b1, 7, 32'h1110_03FF);
      write_tag(7, 32'h0020_0000);            // valid bit clear
      search("R2", 32'h0020_03FF, 1'b1, 10, 32'h2220_03FF);
   endtask

   task automatic t_pid();
      pid_cur = 8'd0;
      write_tag(20, 32'h0040_0040);           // global entry
      write_data(20, 32'h0900_0000, 6'h03);
      pid_cur = 8'd9;
      search("R3", 32'h0040_0010, 1'b1, 20, 32'h0900_0010);
      write_tag(21, 32'h0050_0040);           // owned by pid 9
      write_data(21, 32'h0A00_0000, 6'h04);
      search("R3", 32'h0050_0020, 1'b1, 21, 32'h0A00_0020);
      pid_cur = 8'd4;
      search("R4", 32'h0050_0020, 1'b0, 0, '0);
      search("R3", 32'h0040_0011, 1'b1, 20, 32'h0900_0011);
      pid_cur = 8'd9;
      search("R4", 32'h0050_0021, 1'b1, 21, 32'h0A00_0021);
   endtask

   task automatic t_sizes();
      pid_cur = 8'd0;
      write_tag(30, 32'h0123_4FC0);           // 16 MiB, unaligned base
      write_data(30, 32'h4567_8000, 6'h05);
      search("R6", 32'h01FE_DCBA, 1'b1, 30, 32'h45FE_DCBA);
      search("R6", 32'h0100_0000, 1'b1, 30, 32'h4500_0000);
      search("R5", 32'h0200_0000, 1'b0, 0, '0);
      write_tag(40, 32'h0083_01C0);           // 64 KiB
      write_data(40, 32'h7FFF_0000, 6'h06);
      search("R7", 32'h0083_FFFF, 1'b1, 40, 32'h7FFF_FFFF);
      search("R5", 32'h0084_0000, 1'b0, 0, '0);
      write_data(20, 32'h3330_03FF, 6'h07);   // low 10 bits discarded
      search("R7", 32'h0040_0005, 1'b1, 20, 32'h3330_0005);
   endtask

   task automatic t_timing();
      pid_cur = 8'd0;
      @(negedge clk);
      tag_we = 1'b1; wr_idx = IDXW'(50); wr_tag = 32'h0060_0040;
      srch_ea = 32'h0060_0000;
      #1;
      check("R10", "same-cycle hit", 64'(srch_hit), 64'h0);
      @(negedge clk);
      tag_we = 1'b0;
      #1;
      check("R10", "next-cycle hit", 64'(srch_hit), 64'h1);
      check("R10", "next-cycle result", 64'(srch_result), 64'd50);
   endtask

   task automatic t_data_only();
      write_data(50, 32'h0C00_0000, 6'h08);
      search("R11", 32'h0060_0123, 1'b1, 50, 32'h0C00_0123);
      check("R11", "perm", 64'(srch_perm), 64'h08);
      write_data(51, 32'h0D00_0000, 6'h09);   // never tagged
      search("R11", 32'h0070_0000, 1'b0, 0, '0);
      check("R9", "cr0 miss so=0", 64'(cr0), 64'h0);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_priority();
      t_pid();
      t_sizes();
      t_timing();
      t_data_only();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 200000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule